// File: doc/BRIEF.md
# Bus Master Transfer Controller

This block sits between a local command source and a shared 32-bit system bus. The command source asks for one transfer: a read or a write, a start address, a burst code and a lock flag. The controller then asks the arbiter for the bus and waits for the grant. After that it issues the beats of a single transfer or of a fixed-length incrementing burst. It watches the slave's ready and two-bit response on every beat.

The controller tracks its own beat count and address. It has a separate path for writes and one for reads. If the grant is taken away in the middle of a transfer, the path parks in its own holding state and remembers which state it left. When the grant returns it resumes in that same state. A RETRY or SPLIT response makes it ask for the bus again and replay the beat that was refused. An ERROR response ends the transfer and is reported to the command side.

The bus protocol is single-stage: a beat is taken in the cycle where grant, ready and an OKAY response are all seen together. Outputs that depend on the grant are Mealy outputs, so they react to `hgrant` in the same cycle.

Top module: `bmx_master`

## Requirements
- R1: While `hrstn` is low, and after reset until a command arrives, `cmd_busy`, `hbusreq` and `hlock` are 0 and `htrans` is IDLE (2'b00).
- R2: In idle the block waits for `cmd_req`. In that cycle it captures `cmd_write`, `cmd_addr`, `cmd_burst` and `cmd_lock`, and from the next cycle it holds `hbusreq` high. While `hgrant` stays low it keeps `htrans` at IDLE.
- R3: After the grant is seen, the next cycle presents the first beat at the captured address. This beat has `htrans` = NONSEQ (2'b10), and `hwrite` equals the captured write flag.
- R4: The burst length is 4, 8 or 16 beats for `hburst` codes 3'b011, 3'b101 and 3'b111. Every beat after the first carries `htrans` = SEQ (2'b11), and the address rises by 4 on each beat that is taken, except the last one.
- R5: A beat is taken only when `hgrant`, `hready` and an OKAY response (2'b00) are all present together. While `hready` is 0, the address and the beat position stay the same.
- R6: After the last beat is taken, `htrans` goes to IDLE. `cmd_done` then pulses for one cycle in which `hgrant`, `hready` and OKAY are all present, and the block returns to idle.
- R7: If `hgrant` drops during a beat or during the completion phase, the block keeps `hbusreq` high, drives `htrans` IDLE and holds the address. When the grant returns it resumes in the same phase, so a burst interrupted at a middle beat carries on with SEQ.
- R8: A RETRY (2'b10) or SPLIT (2'b11) response makes the block re-request the bus. It does not advance, and after the new grant it replays the refused beat at the same address as NONSEQ.
- R9: An ERROR response (2'b01) during a beat or the completion phase pulses `cmd_err` in that cycle, and the block returns to idle on the next cycle.
- R10: `rd_valid` pulses on each read beat that is taken, with `rd_data` equal to `hrdata`. `hwdata` follows `cmd_wdata`, `hsize` is 3'b010, `hburst` is the captured code and `hlock` is the captured lock flag while busy.
- R11: Any `hburst` code other than the three listed in R4 runs as a single beat.
- R12: Changes on the command inputs while the block is busy, including `cmd_req`, have no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Clock |
| hrstn | input | 1 | Active-low reset |
| cmd_req | input | 1 | Start a transfer (sampled in idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Start address |
| cmd_burst | input | 3 | Burst code |
| cmd_lock | input | 1 | Locked transfer request |
| cmd_wdata | input | 32 | Write data for the current beat |
| cmd_busy | output | 1 | Transfer in progress |
| cmd_done | output | 1 | Transfer finished with OKAY |
| cmd_err | output | 1 | Transfer aborted by ERROR |
| rd_data | output | 32 | Read data of the taken beat |
| rd_valid | output | 1 | Read beat taken |
| hbusreq | output | 1 | Bus request to the arbiter |
| hlock | output | 1 | Locked access indication |
| hgrant | input | 1 | Grant from the arbiter |
| htrans | output | 2 | Transfer type |
| haddr | output | 32 | Beat address |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size (word) |
| hburst | output | 3 | Burst code |
| hwdata | output | 32 | Write data |
| hrdata | input | 32 | Read data from the slave |
| hready | input | 1 | Slave ready |
| hresp | input | 2 | Slave response |

## Verification
The bench removes the grant at a middle beat and again during the completion phase. A design that resumed at the first phase would show NONSEQ or a rewound address, and one that lost its saved phase would restart or hang. It sends RETRY at a middle beat and SPLIT in the completion phase, which catches a design that advances past the refused beat or replays it as SEQ. It also holds `hready` low inside a burst, uses an unlisted burst code, and changes the command inputs while busy. An off-by-one in the beat count then shows up as one beat too many or too few, and a design that samples its inputs too late shows up as a wrong address or direction.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ASK,
    ST_WR_FIRST, ST_WR_NEXT, ST_WR_TAIL, ST_WR_PARK,
    ST_RD_FIRST, ST_RD_NEXT, ST_RD_TAIL, ST_RD_PARK
  } bmx_state_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERR   = 2'b01;

  localparam int unsigned LEN_W = 5;
  localparam int unsigned CNT_W = LEN_W - 1;

  // beats in a burst for a given code; unlisted codes run as one beat
  function automatic logic [LEN_W-1:0] burst_beats(input logic [2:0] code);
    case (code)
      3'b011:  burst_beats = LEN_W'(4);
      3'b101:  burst_beats = LEN_W'(8);
      3'b111:  burst_beats = LEN_W'(16);
      default: burst_beats = LEN_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/bmx_cmd_track.sv
module bmx_cmd_track
  import bmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [2:0]        ld_burst,
  input  logic              ld_write,
  input  logic              ld_lock,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        burst,
  output logic              write,
  output logic              lock,
  output logic              last
);
  localparam int BYTES = DATA_W / 8;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      addr  <= '0;
      burst <= '0;
      write <= 1'b0;
      lock  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      addr  <= ld_addr;
      burst <= ld_burst;
      write <= ld_write;
      lock  <= ld_lock;
      cnt_q <= '0;
    end else if (step) begin
      addr  <= addr + ADDR_W'(BYTES);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = ({1'b0, cnt_q} == (burst_beats(burst) - LEN_W'(1)));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstn)
    {1'b0, cnt_q} < burst_beats(burst));

endmodule

// File: rtl/bmx_park_slot.sv
module bmx_park_slot
  import bmx_pkg::*;
(
  input  logic       clk,
  input  logic       rstn,
  input  logic       save,
  input  bmx_state_e cur,
  output bmx_state_e held
);
  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn)     held <= ST_IDLE;
    else if (save) held <= cur;
  end
endmodule

// File: rtl/bmx_master.sv
module bmx_master
  import bmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              hclk,
  input  logic              hrstn,
  input  logic              cmd_req,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [2:0]        cmd_burst,
  input  logic              cmd_lock,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              hbusreq,
  output logic              hlock,
  input  logic              hgrant,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  input  logic [1:0]        hresp
);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

  bmx_state_e state_q, state_d, park_state;
  logic wr_q, lock_q, last_beat;

  // named internal events
  logic at_first, at_next, at_tail, in_beat, in_xfer;
  logic grant_lost, resp_err, resp_rewind, beat_take, tail_done, load_cmd, step_addr;

  assign at_first = (state_q == ST_WR_FIRST) || (state_q == ST_RD_FIRST);
  assign at_next  = (state_q == ST_WR_NEXT)  || (state_q == ST_RD_NEXT);
  assign at_tail  = (state_q == ST_WR_TAIL)  || (state_q == ST_RD_TAIL);
  assign in_beat  = at_first || at_next;
  assign in_xfer  = in_beat || at_tail;

  assign grant_lost  = in_xfer && !hgrant;
  assign resp_err    = in_xfer && hgrant && (hresp == RSP_ERR);
  assign resp_rewind = in_xfer && hgrant && hresp[1];
  assign beat_take   = in_beat && hgrant && hready && (hresp == RSP_OKAY);
  assign tail_done   = at_tail && hgrant && hready && (hresp == RSP_OKAY);
  assign load_cmd    = (state_q == ST_IDLE) && cmd_req;
  assign step_addr   = beat_take && !last_beat;

  bmx_cmd_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
    .clk(hclk), .rstn(hrstn), .load(load_cmd), .step(step_addr),
    .ld_addr(cmd_addr), .ld_burst(cmd_burst), .ld_write(cmd_write), .ld_lock(cmd_lock),
    .addr(haddr), .burst(hburst), .write(wr_q), .lock(lock_q), .last(last_beat)
  );

  bmx_park_slot u_park (
    .clk(hclk), .rstn(hrstn), .save(grant_lost), .cur(state_q), .held(park_state)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (cmd_req) state_d = ST_ASK;
      ST_ASK:     if (hgrant)  state_d = wr_q ? ST_WR_FIRST : ST_RD_FIRST;
      ST_WR_PARK,
      ST_RD_PARK: if (hgrant)  state_d = park_state;
      default: begin
        if (grant_lost)       state_d = wr_q ? ST_WR_PARK : ST_RD_PARK;
        else if (resp_err)    state_d = ST_IDLE;
        else if (resp_rewind) state_d = ST_ASK;
        else if (beat_take)   state_d = last_beat ? (wr_q ? ST_WR_TAIL : ST_RD_TAIL)
                                                  : (wr_q ? ST_WR_NEXT : ST_RD_NEXT);
        else if (tail_done)   state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge hclk or negedge hrstn) begin
    if (!hrstn) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Mealy transfer type: a beat is only driven while granted
  always_comb begin
    htrans = TR_IDLE;
    if (hgrant && at_first) htrans = TR_NONSEQ;
    if (hgrant && at_next)  htrans = TR_SEQ;
  end

  assign cmd_busy = (state_q != ST_IDLE);
  assign hbusreq  = cmd_busy;
  assign hlock    = cmd_busy && lock_q;
  assign hwrite   = wr_q;
  assign hsize    = SIZE_CODE;
  assign hwdata   = cmd_wdata;
  assign rd_data  = hrdata;
  assign rd_valid = beat_take && !wr_q;
  assign cmd_done = tail_done;
  assign cmd_err  = resp_err;

  // R4
  accept_step_chk: assert property (@(posedge hclk) disable iff (!hrstn)
    (htrans != TR_IDLE && hready && hresp == RSP_OKAY && !last_beat)
      |=> haddr == $past(haddr) + ADDR_W'(DATA_W / 8));

  // R6
  done_idle_chk: assert property (@(posedge hclk) disable iff (!hrstn)
    cmd_done |=> (!cmd_busy && !hbusreq));

  // R7
  park_hold_chk: assert property (@(posedge hclk) disable iff (!hrstn)
    grant_lost |=> (hbusreq && htrans == TR_IDLE && $stable(haddr)));

  // R8
  rewind_hold_chk: assert property (@(posedge hclk) disable iff (!hrstn)
    (htrans != TR_IDLE && hresp[1]) |=> (hbusreq && htrans == TR_IDLE && $stable(haddr)));

  // R9
  err_release_chk: assert property (@(posedge hclk) disable iff (!hrstn)
    cmd_err |=> !cmd_busy);

endmodule

// File: tb/sim_bmx_master.sv
`timescale 1ns/1ps
module sim_bmx_master;
  logic        hclk = 1'b0;
  logic        hrstn = 1'b0;
  logic        cmd_req = 1'b0, cmd_write = 1'b0, cmd_lock = 1'b0;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic [2:0]  cmd_burst = '0;
  logic        hgrant = 1'b0, hready = 1'b0;
  logic [1:0]  hresp = 2'b00;
  logic [31:0] hrdata = '0;
  logic        cmd_busy, cmd_done, cmd_err, rd_valid, hbusreq, hlock, hwrite;
  logic [31:0] rd_data, haddr, hwdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;

  always #2.5 hclk = ~hclk;

  bmx_master u0 (
    .hclk(hclk), .hrstn(hrstn), .cmd_req(cmd_req), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_lock(cmd_lock), .cmd_wdata(cmd_wdata),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_err(cmd_err), .rd_data(rd_data),
    .rd_valid(rd_valid), .hbusreq(hbusreq), .hlock(hlock), .hgrant(hgrant),
    .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string tag = "R1";

  // reference model: phase numbers are the bench's own view of progress
  localparam int P_IDLE = 0, P_ASK = 1, P_FIRST = 2, P_MID = 3, P_TAIL = 4, P_PARK = 5;
  int ph = P_IDLE, saved = P_IDLE, m_len = 1, m_cnt = 0;
  logic [31:0] m_addr = '0;
  logic [2:0]  m_burst = '0;
  logic        m_wr = 1'b0, m_lock = 1'b0;

  function automatic int len_of(logic [2:0] c);
    if (c == 3'b011) return 4;
    if (c == 3'b101) return 8;
    if (c == 3'b111) return 16;
    return 1;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit busy = (ph != P_IDLE);
    bit inx  = (ph == P_FIRST) || (ph == P_MID) || (ph == P_TAIL);
    bit ok   = hgrant && hready && (hresp == 2'b00);
    logic [1:0] etr = 2'b00;
    if (hgrant && ph == P_FIRST) etr = 2'b10;
    if (hgrant && ph == P_MID)   etr = 2'b11;
    chk("cmd_busy", 32'(cmd_busy), 32'(busy));
    chk("hbusreq",  32'(hbusreq),  32'(busy));
    chk("htrans",   32'(htrans),   32'(etr));
    chk("cmd_done", 32'(cmd_done), 32'(ph == P_TAIL && ok));
    chk("cmd_err",  32'(cmd_err),  32'(inx && hgrant && hresp == 2'b01));
    chk("rd_valid", 32'(rd_valid), 32'((ph == P_FIRST || ph == P_MID) && ok && !m_wr));
    chk("hlock",    32'(hlock),    32'(busy && m_lock));
    chk("hsize",    32'(hsize),    32'd2);
    chk("hwdata",   hwdata,        cmd_wdata);
    if (busy) begin
      chk("haddr",  haddr,         m_addr);
      chk("hwrite", 32'(hwrite),   32'(m_wr));
      chk("hburst", 32'(hburst),   32'(m_burst));
    end
    if (rd_valid) chk("rd_data", rd_data, hrdata);
  endtask

  task automatic model_step();
    case (ph)
      P_IDLE: if (cmd_req) begin
        m_addr = cmd_addr; m_wr = cmd_write; m_burst = cmd_burst; m_lock = cmd_lock;
        m_len = len_of(cmd_burst); m_cnt = 0; ph = P_ASK;
      end
      P_ASK:  if (hgrant) ph = P_FIRST;
      P_PARK: if (hgrant) ph = saved;
      default: begin
        if (!hgrant) begin saved = ph; ph = P_PARK; end
        else if (hresp == 2'b01) ph = P_IDLE;
        else if (hresp[1]) ph = P_ASK;
        else if (hready) begin
          if (ph == P_TAIL) ph = P_IDLE;
          else if (m_cnt == m_len - 1) ph = P_TAIL;
          else begin m_cnt++; m_addr += 32'd4; ph = P_MID; end
        end
      end
    endcase
  endtask

  task automatic tick();
    #1;
    compare();
    model_step();
    @(posedge hclk);
    @(negedge hclk);
  endtask

  task automatic drive(bit g, bit r, logic [1:0] rs, int n);
    for (int i = 0; i < n; i++) begin
      hgrant = g; hready = r; hresp = rs;
      hrdata = hrdata + 32'h0101_0011;
      cmd_wdata = cmd_wdata + 32'h0000_0203;
      tick();
    end
  endtask

  task automatic issue(bit wr, logic [31:0] a, logic [2:0] b, bit lk);
    cmd_write = wr; cmd_addr = a; cmd_burst = b; cmd_lock = lk; cmd_req = 1'b1;
    hgrant = 1'b0; hready = 1'b1; hresp = 2'b00;
    tick();
    cmd_req = 1'b0;
  endtask

  initial begin
    @(negedge hclk);
    // R1: values held in reset
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("reset busy",   32'(cmd_busy), 32'd0);
      chk("reset busreq", 32'(hbusreq),  32'd0);
      chk("reset htrans", 32'(htrans),   32'd0);
      @(negedge hclk);
    end
    hrstn = 1'b1;
    drive(1'b1, 1'b1, 2'b00, 2);

    tag = "R2"; issue(1'b1, 32'h0000_1000, 3'b000, 1'b0);
    drive(1'b0, 1'b1, 2'b00, 3);
    tag = "R3"; drive(1'b1, 1'b1, 2'b00, 4);

    tag = "R4"; issue(1'b0, 32'h0000_2000, 3'b011, 1'b0); drive(1'b1, 1'b1, 2'b00, 8);
    issue(1'b1, 32'h0000_3000, 3'b101, 1'b0); drive(1'b1, 1'b1, 2'b00, 12);
    issue(1'b0, 32'h0000_4000, 3'b111, 1'b1); drive(1'b1, 1'b1, 2'b00, 20);

    tag = "R5"; issue(1'b0, 32'h0000_5000, 3'b011, 1'b0);
    drive(1'b1, 1'b1, 2'b00, 2); drive(1'b1, 1'b0, 2'b00, 3); drive(1'b1, 1'b1, 2'b00, 6);

    tag = "R6"; issue(1'b1, 32'h0000_5800, 3'b000, 1'b0);
    drive(1'b1, 1'b1, 2'b00, 2); drive(1'b1, 1'b0, 2'b00, 2); drive(1'b1, 1'b1, 2'b00, 3);

    tag = "R7"; issue(1'b1, 32'h0000_6000, 3'b101, 1'b0);
    drive(1'b1, 1'b1, 2'b00, 4); drive(1'b0, 1'b1, 2'b00, 3); drive(1'b1, 1'b1, 2'b00, 10);
    issue(1'b0, 32'h0000_6800, 3'b000, 1'b0);
    drive(1'b1, 1'b1, 2'b00, 2); drive(1'b0, 1'b1, 2'b00, 2); drive(1'b1, 1'b1, 2'b00, 3);

    tag = "R8"; issue(1'b0, 32'h0000_7000, 3'b011, 1'b0);
    drive(1'b1, 1'b1, 2'b00, 3); drive(1'b1, 1'b0, 2'b10, 1); drive(1'b1, 1'b1, 2'b00, 8);
    issue(1'b1, 32'h0000_7800, 3'b000, 1'b0);
    drive(1'b1, 1'b1, 2'b00, 2); drive(1'b1, 1'b1, 2'b11, 1); drive(1'b1, 1'b1, 2'b00, 5);

    tag = "R9"; issue(1'b1, 32'h0000_8000, 3'b011, 1'b0);
    drive(1'b1, 1'b1, 2'b00, 2); drive(1'b1, 1'b0, 2'b01, 1); drive(1'b1, 1'b1, 2'b00, 3);

    tag = "R10"; issue(1'b0, 32'h0000_9000, 3'b011, 1'b1); drive(1'b1, 1'b1, 2'b00, 7);

    tag = "R11"; issue(1'b0, 32'h0000_A000, 3'b001, 1'b0); drive(1'b1, 1'b1, 2'b00, 4);

    tag = "R12"; issue(1'b1, 32'h0000_B000, 3'b011, 1'b0);
    cmd_req = 1'b1; cmd_addr = 32'h0000_FFF0; cmd_write = 1'b0; cmd_burst = 3'b111; cmd_lock = 1'b1;
    drive(1'b1, 1'b1, 2'b00, 3);
    cmd_req = 1'b0;
    drive(1'b1, 1'b1, 2'b00, 6);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge hclk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule